// File: doc/BRIEF.md
# Interlocked Glitch-Free Clock Selector

This block chooses the source of a base clock. One source is a crystal reference clock and the other is a free-running VCO clock. On a change of source it gates the old clock off, then gates the new one on. The gating is handshaked across both clock domains, and the output stays at a constant level while the handshake runs. A toggle flop after the gated mux gives a 50% duty base clock, and a second toggle flop halves that again to give the bus clock.

A small register port clocked by the reference clock holds three things: a select bit, a PLL-enable bit and a programming byte. The programming byte carries a multiplier N and a loop field L. Interlocks refuse any write that would leave the VCO driving the output while the PLL is off or disabled. A read-only status bit reports which clock drives the output.

Top module: `clk_src_switch`

## Requirements
- R1: After an accepted change of the select bit, the old clock's gate closes before the new clock's gate opens. The two gates are never open together. `src_vco` equals the select bit within 12 reference cycles of the write.
- R2: While a switch is in progress, `base_clk` holds a constant level. It never shows a high or low phase shorter than one period of the faster input clock.
- R3: `base_clk` toggles once per rising edge of the selected input, so it runs at half the input frequency. `bus_clk` runs at half of `base_clk`.
- R4: A control write that tries to set the select bit while the PLL-enable bit is 0 leaves the select bit at 0 (crystal).
- R5: A control write that tries to clear the PLL-enable bit while the select bit is 1 leaves the PLL-enable bit at 1.
- R6: A control write whose data differs from the current value in both the select bit and the PLL-enable bit changes neither bit.
- R7: A write with `wr_addr`=1 loads N from `wr_data[7:4]` and L from `wr_data[3:0]`. `mult_n` reports 1 when N is 0 and reports N otherwise. `mult_l` reports L.
- R8: While L is 0, setting the select bit is refused. While the select bit is 1, a programming write with L=0 is refused, and N and L keep their values.
- R9: Reset selects the crystal, clears the PLL-enable bit, clears N and L, and starts both divider flops at 0.
- R10: A write with `wr_addr`=0 is a control write. `wr_data[0]` is the select bit (1 = VCO) and `wr_data[1]` is the PLL-enable bit. Accepted values appear on `sel_vco` and `pll_on` after the reference edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Crystal reference clock; also clocks the register port |
| vco_clk | input | 1 | Free-running VCO clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control bits, 1 = programming byte |
| wr_data | input | 8 | Write data |
| base_clk | output | 1 | Selected clock divided by two |
| bus_clk | output | 1 | Base clock divided by two |
| sel_vco | output | 1 | Stored select bit |
| pll_on | output | 1 | Stored PLL-enable bit |
| mult_n | output | 4 | Effective multiplier N |
| mult_l | output | 4 | Stored L field |
| src_vco | output | 1 | 1 when the VCO gate is open |

## Verification
Register results (`sel_vco`, `pll_on`, `mult_n`, `mult_l`) are due on the reference edge that takes the write. The bench drives each write at a falling edge and checks the registers at the next falling edge, one edge later. `src_vco` follows a switch only after two synchronizer stages on each side plus a falling-edge gate flop and a sync back. The bench therefore waits at least 12 reference cycles after each write before it compares `src_vco`. Frequencies are checked by counting `base_clk` and `bus_clk` edges over a 480 ns window that starts once the switch has settled. Runt phases are caught by tracking the shortest interval between `base_clk` edges over the whole run.

// File: rtl/clk_src_switch.sv
`timescale 1ns/1ps
module clk_src_switch #(
  parameter int FW = 4
) (
  input  logic          ref_clk,
  input  logic          vco_clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [2*FW-1:0] wr_data,
  output logic          base_clk,
  output logic          bus_clk,
  output logic          sel_vco,
  output logic          pll_on,
  output logic [FW-1:0] mult_n,
  output logic [FW-1:0] mult_l,
  output logic          src_vco
);
  localparam int DW = 2*FW;

  logic          sel_q, on_q;
  logic [FW-1:0] n_q, l_q;
  logic [1:0]    rsync, vsync, ssync;
  logic          ref_en, vco_en, base_q, bus_q;

  wire ctl_wr  = wr_en & ~wr_addr;
  wire prg_wr  = wr_en &  wr_addr;
  wire req_sel = wr_data[0];
  wire req_on  = wr_data[1];
  wire l_ok    = |l_q;
  wire clash   = (req_sel != sel_q) && (req_on != on_q);
  wire prg_bad = sel_q && (wr_data[FW-1:0] == '0);

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      sel_q <= 1'b0;
      on_q  <= 1'b0;
      n_q   <= '0;
      l_q   <= '0;
    end else begin
      if (ctl_wr && !clash) begin
        if (req_sel != sel_q)
          sel_q <= req_sel & on_q & l_ok;
        if (req_on != on_q)
          on_q <= req_on | sel_q;
      end
      if (prg_wr && !prg_bad) begin
        n_q <= wr_data[DW-1:FW];
        l_q <= wr_data[FW-1:0];
      end
    end

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) rsync <= 2'b11;
    else        rsync <= {rsync[0], ~sel_q & ~vco_en};

  always_ff @(negedge ref_clk or negedge rst_n)
    if (!rst_n) ref_en <= 1'b1;
    else        ref_en <= rsync[1];

  always_ff @(posedge vco_clk or negedge rst_n)
    if (!rst_n) vsync <= 2'b00;
    else        vsync <= {vsync[0], sel_q & ~ref_en};

  always_ff @(negedge vco_clk or negedge rst_n)
    if (!rst_n) vco_en <= 1'b0;
    else        vco_en <= vsync[1];

  wire mux_clk = (ref_clk & ref_en) | (vco_clk & vco_en);

  always_ff @(posedge mux_clk or negedge rst_n)
    if (!rst_n) base_q <= 1'b0;
    else        base_q <= ~base_q;

  always_ff @(posedge base_q or negedge rst_n)
    if (!rst_n) bus_q <= 1'b0;
    else        bus_q <= ~bus_q;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) ssync <= 2'b00;
    else        ssync <= {ssync[0], vco_en};

  assign base_clk = base_q;
  assign bus_clk  = bus_q;
  assign sel_vco  = sel_q;
  assign pll_on   = on_q;
  assign mult_n   = (n_q == '0) ? FW'(1) : n_q;
  assign mult_l   = l_q;
  assign src_vco  = ssync[1];

  // R1
  exclusive_gate_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(ref_en && vco_en));

  // R2
  held_static_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!ref_en && !vco_en && $past(!ref_en && !vco_en)) |-> $stable(base_q));

  // R4
  vco_needs_pll_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    sel_q |-> (on_q && l_ok));

  // R5
  pll_off_refused_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (ctl_wr && !req_on && sel_q) |=> on_q);

  // R6
  clash_ignored_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (ctl_wr && clash) |=> (sel_q == $past(sel_q) && on_q == $past(on_q)));

  // R8
  l_zero_refused_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (prg_wr && prg_bad) |=> (l_q == $past(l_q) && n_q == $past(n_q)));
endmodule

// File: tb/clk_src_switch_tb.sv
`timescale 1ns/1ps
module clk_src_switch_tb;
  logic ref_clk = 0, vco_clk = 0, rst_n = 0, wr_en = 0, wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic base_clk, bus_clk, sel_vco, pll_on, src_vco;
  logic [3:0] mult_n, mult_l;

  clk_src_switch u_dut (
    .ref_clk(ref_clk), .vco_clk(vco_clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .base_clk(base_clk), .bus_clk(bus_clk), .sel_vco(sel_vco),
    .pll_on(pll_on), .mult_n(mult_n), .mult_l(mult_l), .src_vco(src_vco));

  always #5 ref_clk = ~ref_clk;
  always #3 vco_clk = ~vco_clk;

  int n_chk = 0, n_fail = 0;
  int base_cnt = 0, bus_cnt = 0;
  bit m_sel = 0, m_on = 0;
  logic [3:0] m_n = 0, m_l = 0;
  realtime last_edge = 0, min_gap = 1.0e9;

  always @(posedge base_clk) base_cnt++;
  always @(posedge bus_clk)  bus_cnt++;
  always @(base_clk)
    if (rst_n) begin
      if (last_edge > 0 && ($realtime - last_edge) < min_gap) min_gap = $realtime - last_edge;
      last_edge = $realtime;
    end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_n(logic [3:0] n);
    return (n == 0) ? 4'd1 : n;
  endfunction

  function automatic bit want_sel(bit s, bit o, logic [3:0] l, logic [7:0] d);
    if (d[0] == s || d[1] != o) return s;
    return d[0] & o & (l != 0);
  endfunction

  function automatic bit want_on(bit s, bit o, logic [7:0] d);
    if (d[1] == o || d[0] != s) return o;
    return d[1] | s;
  endfunction

  task automatic check_regs(string tag);
    chk(sel_vco == m_sel, {tag, " sel_vco"}, int'(sel_vco), int'(m_sel));
    chk(pll_on == m_on, {tag, " pll_on"}, int'(pll_on), int'(m_on));
    chk(mult_n == exp_n(m_n), {tag, " mult_n"}, int'(mult_n), int'(exp_n(m_n)));
    chk(mult_l == m_l, {tag, " mult_l"}, int'(mult_l), int'(m_l));
  endtask

  task automatic wr(bit a, logic [7:0] d, string tag);
    bit ns, no;
    @(negedge ref_clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    if (!a) begin
      ns = want_sel(m_sel, m_on, m_l, d);
      no = want_on(m_sel, m_on, d);
      m_sel = ns; m_on = no;
    end else if (!(m_sel && d[3:0] == 0)) begin
      m_n = d[7:4]; m_l = d[3:0];
    end
    @(negedge ref_clk);
    wr_en = 0;
    check_regs(tag);
  endtask

  task automatic settle_src(string tag);
    repeat (12) @(negedge ref_clk);
    chk(src_vco == m_sel, tag, int'(src_vco), int'(m_sel));
  endtask

  task automatic measure(int eb, int eu, string tag);
    @(negedge ref_clk);
    base_cnt = 0; bus_cnt = 0;
    #480;
    chk(base_cnt >= eb - 1 && base_cnt <= eb + 1, {tag, " base edges"}, base_cnt, eb);
    chk(bus_cnt >= eu - 1 && bus_cnt <= eu + 1, {tag, " bus edges"}, bus_cnt, eu);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #200us;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(1234));
    #23 rst_n = 1;
    @(negedge ref_clk);
    check_regs("R9 reset");
    chk(src_vco == 0, "R9 reset src_vco", int'(src_vco), 0);
    chk(base_clk == 0 || base_clk == 1, "R9 base known", int'(base_clk), 0);
    measure(24, 12, "R3 crystal");

    wr(0, 8'h01, "R4 select with pll off");
    wr(0, 8'h03, "R6 both bits change");
    wr(1, 8'h05, "R7 N zero reads one");
    wr(1, 8'h00, "R7 clear fields");
    wr(0, 8'h02, "R10 pll on");
    wr(0, 8'h03, "R8 select with L zero");
    wr(1, 8'hA3, "R7 N and L load");
    wr(0, 8'h03, "R10 select vco");
    settle_src("R1 switch to vco");
    measure(40, 20, "R3 vco");
    wr(0, 8'h01, "R5 pll off refused");
    wr(1, 8'h70, "R8 L zero refused");
    wr(0, 8'h00, "R6 both bits while vco");
    wr(0, 8'h02, "R10 back to crystal");
    settle_src("R1 switch to crystal");
    measure(24, 12, "R3 crystal again");

    for (int i = 0; i < 150; i++) begin
      bit a = 1'($urandom_range(0, 1));
      logic [7:0] d = 8'($urandom);
      if (a && $urandom_range(0, 3) == 0) d[3:0] = 0;
      wr(a, d, "R10 random write");
      settle_src("R1 random src");
    end

    chk(min_gap > 5.5, "R2 shortest base phase ns", int'(min_gap), 6);
    summary();
    $finish;
  end
endmodule